// File: doc/BRIEF.md
# Bus Reset Detect Interrupt and Pull-up Switch Controller

This block sits beside a full-speed/low-speed USB line transceiver and turns a three-bit control word, written by a host processor, into enables for the two pull-up switches on the data lines and for the line-driver mode. The word is made of a suspend bit, a connect bit and an active-low speed bit. A separate high-impedance request overrides the word. All control inputs arrive asynchronously and are brought into the block's clock domain before use.

One code value (suspend 0, connect 1, speed_n 1) arms a detector for a single-ended-zero condition on the bus (both data lines low). The condition must last for a parameterised number of clock cycles before it counts, so skew glitches between the two lines are filtered out. When it counts, the active-low interrupt falls, stays low and the strong 1.5k pull-up switch closes. The host answers by writing one of two acknowledge codes that keep the pull-up on; any other code releases the interrupt and applies that code's own behaviour. Another code connects a weak pull-up used for charger detection and forces the transceiver into receive-only operation.

Top module: `se0_pullup_ctrl`

## Requirements
- R1: The detector and interrupt are armed only while the synchronised control word is 3'b011 (bit 2 suspend, bit 1 connect, bit 0 speed_n) and the high-Z request is low; in every other state int_n is 1 and the detector state is cleared.
- R2: While armed, pu_fs_en is 0 until a qualified single-ended zero has been detected and 1 from then on.
- R3: A single-ended zero is bus_dp = 0 and bus_dm = 0; it is qualified only after it has been sampled on SE0_MIN_CYC consecutive clock edges, and any sample that is not a single-ended zero restarts the count from zero.
- R4: On qualification int_n goes from 1 to 0 after the edge that samples the SE0_MIN_CYC-th single-ended zero and stays 0 while the block remains armed, whatever the bus does.
- R5: Writing 3'b010 or 3'b110 after a detection releases int_n and keeps pu_fs_en at 1 without a gap; returning to 3'b011 afterwards re-arms a fresh detector with pu_fs_en at 0.
- R6: Writing any other code after a detection releases int_n and applies that code's normal outputs.
- R7: Codes 3'b000, 3'b001, 3'b100 and 3'b101 leave both pull-ups off and force_rx at 0; codes 3'b010 and 3'b110 set pu_fs_en to 1.
- R8: Code 3'b111 sets pu_chg_en and force_rx to 1 and keeps pu_fs_en at 0.
- R9: A high high-Z request overrides every code: pu_fs_en, pu_chg_en and force_rx are 0, tri_out is 1 and int_n is 1; tri_out is 0 otherwise.
- R10: Control word and high-Z request pass through SYNC_STAGES flops; a change driven between two edges shows at the outputs after the SYNC_STAGES-th following edge and not before.
- R11: After reset int_n is 1 and pu_fs_en, pu_chg_en, force_rx and tri_out are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_word | input | 3 | Asynchronous control word: [2] suspend, [1] connect, [0] speed_n |
| hiz_req | input | 1 | Asynchronous high-impedance override request |
| bus_dp | input | 1 | Sampled D+ line level |
| bus_dm | input | 1 | Sampled D- line level |
| int_n | output | 1 | Active-low single-ended-zero interrupt |
| pu_fs_en | output | 1 | Close the 1.5k pull-up switch |
| pu_chg_en | output | 1 | Close the weak charger-detect pull-up switch |
| force_rx | output | 1 | Hold the line drivers in receive mode |
| tri_out | output | 1 | Tri-state the transceiver's outputs |

## Verification
The bench builds the block with SE0_MIN_CYC set to 6 and SYNC_STAGES left at 2. The short threshold makes the exact boundary (runs of five and six single-ended-zero samples, and a split run broken by one idle sample) cheap to drive, and lets random bus runs of one to nine cycles cross the threshold often enough that detection, acknowledge and re-arm are all reached many times under random code and high-Z changes. The two-stage default keeps the synchroniser latency check at its normal depth.

// File: rtl/se0c_pkg.sv
// Package: shared types and the code-to-pad decode for the SE0 interrupt
// and pull-up controller. Assumes control bit order [2] suspend,
// [1] connect, [0] speed_n.
package se0c_pkg;

    typedef logic [2:0] ctl_code_t;

    localparam ctl_code_t CODE_ARM    = 3'b011;
    localparam ctl_code_t CODE_ACK_LS = 3'b010;
    localparam ctl_code_t CODE_ACK_HS = 3'b110;
    localparam ctl_code_t CODE_CHARGE = 3'b111;

    typedef struct packed {
        logic pu_fs;
        logic pu_chg;
        logic force_rx;
        logic tri_out;
    } pad_ctl_t;

    // Map a synchronised code, override and detection flag to switch enables.
    function automatic pad_ctl_t decode_pads(ctl_code_t code, logic hiz, logic det);
        pad_ctl_t p;
        p = '0;
        if (hiz) begin
            p.tri_out = 1'b1;
        end else begin
            unique case (code)
                CODE_ACK_LS, CODE_ACK_HS: p.pu_fs = 1'b1;
                CODE_ARM:                 p.pu_fs = det;
                CODE_CHARGE: begin
                    p.pu_chg   = 1'b1;
                    p.force_rx = 1'b1;
                end
                default:                  p = '0;
            endcase
        end
        return p;
    endfunction

endpackage

// File: rtl/se0c_sync.sv
// Multi-flop synchroniser for asynchronous control levels.
// Assumes each input is a quasi-static level; a multi-bit word may be seen
// for one cycle as a mix of old and new bits, which the decode tolerates.
module se0c_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the asynchronous level.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= d_async;
                end
            end else begin : g_next
                // Pass the level one stage down.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/se0c_qualifier.sv
// Deglitching single-ended-zero qualifier with a sticky detection flag.
// Assumes the se0 input is already sampled in this clock domain. While not
// armed the count and the flag are held cleared.
module se0c_qualifier #(
    parameter int MIN_CYC = 26
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic se0,
    output logic detected
);

    localparam int CW = $clog2(MIN_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(MIN_CYC - 1);
    localparam logic [CW-1:0] FULL = CW'(MIN_CYC);

    logic [CW-1:0] run_cnt;

    // Count consecutive SE0 samples; restart on any non-SE0 sample.
    always_ff @(posedge clk) begin
        if (!rst_n || !armed) begin
            run_cnt <= '0;
        end else if (!se0) begin
            run_cnt <= '0;
        end else if (run_cnt != FULL) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // Set the flag on the qualifying sample and hold it while armed.
    always_ff @(posedge clk) begin
        if (!rst_n || !armed) begin
            detected <= 1'b0;
        end else if (se0 && run_cnt == LAST) begin
            detected <= 1'b1;
        end
    end

endmodule

// File: rtl/se0c_pad_decode.sv
// Combinational map from synchronised control state to the pad enables
// and the interrupt. Assumes inputs come from flops of the same clock.
module se0c_pad_decode
    import se0c_pkg::*;
(
    input  ctl_code_t code,
    input  logic      hiz,
    input  logic      detected,
    output logic      armed,
    output logic      int_n,
    output logic      pu_fs_en,
    output logic      pu_chg_en,
    output logic      force_rx,
    output logic      tri_out
);

    pad_ctl_t pads;

    // Decide arming and gate the interrupt by it.
    always_comb begin
        armed = (code == CODE_ARM) && !hiz;
        int_n = !(armed && detected);
    end

    // Drive switch and mode enables from the code table.
    always_comb begin
        pads      = decode_pads(code, hiz, armed && detected);
        pu_fs_en  = pads.pu_fs;
        pu_chg_en = pads.pu_chg;
        force_rx  = pads.force_rx;
        tri_out   = pads.tri_out;
    end

endmodule

// File: rtl/se0_pullup_ctrl.sv
// Top: SE0 interrupt and pull-up switch controller.
// Synchronises the control word and high-Z request, qualifies a long
// single-ended zero while armed, and drives pull-up and mode enables.
// Assumes bus_dp/bus_dm are already sampled in the clk domain.
module se0_pullup_ctrl
    import se0c_pkg::*;
#(
    parameter int SE0_MIN_CYC = 26,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] ctl_word,
    input  logic       hiz_req,
    input  logic       bus_dp,
    input  logic       bus_dm,
    output logic       int_n,
    output logic       pu_fs_en,
    output logic       pu_chg_en,
    output logic       force_rx,
    output logic       tri_out
);

    localparam int CTL_W = $bits(ctl_code_t) + 1;

    logic [CTL_W-1:0] ctl_s;
    ctl_code_t        code_s;
    logic             hiz_s;
    logic             armed;
    logic             detected;
    logic             se0_now;

    se0c_sync #(
        .WIDTH  (CTL_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({hiz_req, ctl_word}),
        .q_sync  (ctl_s)
    );

    // Split the synchronised word into override and code.
    always_comb begin
        hiz_s   = ctl_s[CTL_W-1];
        code_s  = ctl_s[CTL_W-2:0];
        se0_now = !bus_dp && !bus_dm;
    end

    se0c_qualifier #(
        .MIN_CYC (SE0_MIN_CYC)
    ) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .armed    (armed),
        .se0      (se0_now),
        .detected (detected)
    );

    se0c_pad_decode u_dec (
        .code      (code_s),
        .hiz       (hiz_s),
        .detected  (detected),
        .armed     (armed),
        .int_n     (int_n),
        .pu_fs_en  (pu_fs_en),
        .pu_chg_en (pu_chg_en),
        .force_rx  (force_rx),
        .tri_out   (tri_out)
    );

endmodule

// File: rtl/se0_pullup_ctrl_chk.sv
// Checker: temporal properties of the SE0 interrupt and pull-up controller,
// bound to the top module. Assumes it sees the synchronised code and
// override from inside the top.
module se0_pullup_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] code_s,
    input logic       hiz_s,
    input logic       bus_dp,
    input logic       bus_dm,
    input logic       int_n,
    input logic       pu_fs_en,
    input logic       pu_chg_en,
    input logic       force_rx,
    input logic       tri_out
);

    AST_INT_ONLY_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        !int_n |-> (code_s == 3'b011 && !hiz_s)); // R1

    AST_FS_FOLLOWS_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
        (code_s == 3'b011 && !hiz_s) |-> (pu_fs_en == !int_n)); // R2

    AST_FALL_NEEDS_SE0: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_n) |-> $past(!bus_dp && !bus_dm)); // R3

    AST_INT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !int_n |=> (!int_n || code_s != 3'b011 || hiz_s)); // R4

    AST_CHARGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        pu_chg_en |-> (!pu_fs_en && force_rx)); // R8

    AST_HIZ_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        hiz_s |-> (tri_out && !pu_fs_en && !pu_chg_en && !force_rx && int_n)); // R9

endmodule

bind se0_pullup_ctrl se0_pullup_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .code_s    (code_s),
    .hiz_s     (hiz_s),
    .bus_dp    (bus_dp),
    .bus_dm    (bus_dm),
    .int_n     (int_n),
    .pu_fs_en  (pu_fs_en),
    .pu_chg_en (pu_chg_en),
    .force_rx  (force_rx),
    .tri_out   (tri_out)
);

// File: tb/test_se0_pullup_ctrl.sv
// Bench: directed corner cases plus seeded random stimulus, compared
// against a requirement-level model kept in the bench.
module test_se0_pullup_ctrl;

    localparam int MIN = 6;
    localparam int SYN = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] ctl_word = 3'b000;
    logic       hiz_req = 1'b0;
    logic       bus_dp = 1'b1;
    logic       bus_dm = 1'b0;
    logic       int_n, pu_fs_en, pu_chg_en, force_rx, tri_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    se0_pullup_ctrl #(
        .SE0_MIN_CYC (MIN),
        .SYNC_STAGES (SYN)
    ) i_se0_pullup_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_word  (ctl_word),
        .hiz_req   (hiz_req),
        .bus_dp    (bus_dp),
        .bus_dm    (bus_dm),
        .int_n     (int_n),
        .pu_fs_en  (pu_fs_en),
        .pu_chg_en (pu_chg_en),
        .force_rx  (force_rx),
        .tri_out   (tri_out)
    );

    // Requirement model: sync pipeline, run counter and sticky flag.
    logic [3:0] m_pipe [SYN];
    int         m_cnt;
    logic       m_det;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SYN; i++) m_pipe[i] <= 4'h0;
            m_cnt <= 0;
            m_det <= 1'b0;
        end else begin
            m_pipe[0] <= {hiz_req, ctl_word};
            for (int i = 1; i < SYN; i++) m_pipe[i] <= m_pipe[i-1];
            if (!(m_pipe[SYN-1][2:0] == 3'b011 && !m_pipe[SYN-1][3])) begin
                m_cnt <= 0;
                m_det <= 1'b0;
            end else if (!bus_dp && !bus_dm) begin
                if (m_cnt == MIN - 1) m_det <= 1'b1;
                if (m_cnt < MIN) m_cnt <= m_cnt + 1;
            end else begin
                m_cnt <= 0;
            end
        end
    end

    // Expected {int_n, pu_fs_en, pu_chg_en, force_rx, tri_out}.
    function automatic logic [4:0] exp_out(logic [2:0] c, logic h, logic d);
        logic arm;
        logic [4:0] r;
        arm = (c == 3'b011) && !h;
        r = 5'b0;
        r[4] = !(arm && d);
        if (h) begin
            r[0] = 1'b1;
        end else begin
            r[3] = (c == 3'b010) || (c == 3'b110) || (c == 3'b011 && d);
            r[2] = (c == 3'b111);
            r[1] = (c == 3'b111);
        end
        return r;
    endfunction

    task automatic chk(logic act, logic exp, string req, string what);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic chk_model();
        logic [4:0] e;
        e = exp_out(m_pipe[SYN-1][2:0], m_pipe[SYN-1][3], m_det);
        chk(int_n,     e[4], "R4", "int_n vs model");
        chk(pu_fs_en,  e[3], "R2", "pu_fs_en vs model");
        chk(pu_chg_en, e[2], "R8", "pu_chg_en vs model");
        chk(force_rx,  e[1], "R8", "force_rx vs model");
        chk(tri_out,   e[0], "R9", "tri_out vs model");
    endtask

    task automatic tick(int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic line_idle();
        bus_dp = 1'b1;
        bus_dm = 1'b0;
    endtask

    task automatic line_se0();
        bus_dp = 1'b0;
        bus_dm = 1'b0;
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int run_left;
        logic run_se0;
        run_left = 0;
        run_se0  = 1'b0;
        tick(3);
        // r11_ reset state
        chk(int_n, 1'b1, "R11", "int_n after reset");
        chk(pu_fs_en, 1'b0, "R11", "pu_fs_en after reset");
        chk(pu_chg_en, 1'b0, "R11", "pu_chg_en after reset");
        chk(tri_out, 1'b0, "R11", "tri_out after reset");
        rst_n = 1'b1;
        tick(3);

        // R10: latency of the synchroniser
        ctl_word = 3'b010;
        tick(SYN - 1);
        chk(pu_fs_en, 1'b0, "R10", "pu_fs_en before sync");
        tick(1);
        chk(pu_fs_en, 1'b1, "R10", "pu_fs_en after sync");

        // R7: static codes
        for (int k = 0; k < 4; k++) begin
            logic [2:0] cs [4];
            cs = '{3'b000, 3'b001, 3'b100, 3'b101};
            ctl_word = cs[k];
            tick(SYN + 1);
            chk(pu_fs_en, 1'b0, "R7", "pu_fs_en on plain code");
            chk(pu_chg_en, 1'b0, "R7", "pu_chg_en on plain code");
            chk(force_rx, 1'b0, "R7", "force_rx on plain code");
        end
        ctl_word = 3'b110;
        tick(SYN + 1);
        chk(pu_fs_en, 1'b1, "R7", "pu_fs_en on 110");

        // R1: long SE0 outside code 011 raises nothing
        ctl_word = 3'b000;
        line_se0();
        tick(SYN + 2 * MIN);
        chk(int_n, 1'b1, "R1", "int_n on code 000 with SE0");
        line_idle();

        // R3: glitch one short of threshold, then a split run
        ctl_word = 3'b011;
        tick(SYN + 1);
        chk(pu_fs_en, 1'b0, "R2", "pu_fs_en armed, no SE0");
        line_se0();
        tick(MIN - 1);
        line_idle();
        tick(3);
        chk(int_n, 1'b1, "R3", "int_n after short SE0");
        line_se0();
        tick(MIN - 1);
        line_idle();
        tick(1);
        line_se0();
        tick(MIN - 1);
        line_idle();
        tick(2);
        chk(int_n, 1'b1, "R3", "int_n after split SE0 run");

        // R4: exact threshold then sticky low
        line_se0();
        tick(MIN - 1);
        chk(int_n, 1'b1, "R4", "int_n one sample early");
        tick(1);
        chk(int_n, 1'b0, "R4", "int_n on qualifying sample");
        chk(pu_fs_en, 1'b1, "R2", "pu_fs_en after detect");
        line_idle();
        tick(20);
        chk(int_n, 1'b0, "R4", "int_n held low");

        // R5: acknowledge with 010 keeps pull-up on
        ctl_word = 3'b010;
        for (int k = 0; k < SYN + 2; k++) begin
            chk(pu_fs_en, 1'b1, "R5", "pu_fs_en across acknowledge");
            tick(1);
        end
        chk(int_n, 1'b1, "R5", "int_n released by 010");
        ctl_word = 3'b011;
        tick(SYN + 1);
        chk(pu_fs_en, 1'b0, "R5", "pu_fs_en after re-arm");
        chk(int_n, 1'b1, "R5", "int_n after re-arm");

        // R6: detect again, then leave with 000
        line_se0();
        tick(MIN + 1);
        line_idle();
        chk(int_n, 1'b0, "R6", "int_n before other code");
        ctl_word = 3'b000;
        tick(SYN);
        chk(int_n, 1'b1, "R6", "int_n released by 000");
        chk(pu_fs_en, 1'b0, "R6", "pu_fs_en on 000");

        // R8: charger code
        ctl_word = 3'b111;
        line_se0();
        tick(SYN + 2 * MIN);
        chk(pu_chg_en, 1'b1, "R8", "pu_chg_en on 111");
        chk(force_rx, 1'b1, "R8", "force_rx on 111");
        chk(pu_fs_en, 1'b0, "R8", "pu_fs_en on 111");
        chk(int_n, 1'b1, "R1", "int_n on 111 with SE0");

        // R9: override on top of 011 with long SE0 and on 010
        ctl_word = 3'b011;
        hiz_req = 1'b1;
        tick(SYN + 2 * MIN);
        chk(int_n, 1'b1, "R9", "int_n under override");
        chk(tri_out, 1'b1, "R9", "tri_out under override");
        ctl_word = 3'b010;
        tick(SYN + 1);
        chk(pu_fs_en, 1'b0, "R9", "pu_fs_en under override");
        hiz_req = 1'b0;
        line_idle();
        tick(SYN + 1);
        chk(tri_out, 1'b0, "R9", "tri_out after override");

        // Random phase against the model.
        void'($urandom(32'd1234));
        for (int cyc = 0; cyc < 6000; cyc++) begin
            if ($urandom_range(15) == 0) ctl_word = 3'($urandom_range(7));
            if ($urandom_range(15) == 0) ctl_word = 3'b011;
            if ($urandom_range(60) == 0) hiz_req = ~hiz_req;
            if (run_left == 0) begin
                run_se0  = ($urandom_range(1) == 0);
                run_left = $urandom_range(1, MIN + 3);
            end
            if (run_se0) begin
                line_se0();
            end else begin
                bus_dp = 1'($urandom_range(1));
                bus_dm = !bus_dp;
            end
            run_left--;
            tick(1);
            chk_model();
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule